// File: doc/BRIEF.md
# Microinstruction Field-Decoded Register Datapath

This block is the register-transfer half of a microprogrammed processor. A sequencer elsewhere delivers three 3-bit operation fields on every clock. The block decodes each field into one of eight fixed register transfers and applies all of them on the same clock edge. The state it holds is a 16-bit accumulator, a 16-bit data register, an 11-bit address register, an 11-bit program counter and a 2048-word by 16-bit memory. Every transfer reads the values the registers held before the edge, so transfers chosen by different fields never see each other's results.

Sometimes two or three fields write the accumulator in the same cycle. When that happens, the third field takes precedence over the second, and the second over the first. The block returns four status values to the sequencer: the accumulator sign bit, an accumulator-is-zero flag, the data register's top bit, and the data register's bits 14 down to 11. The sequencer uses the last of these to pick a routine. All four registers are also driven out as ports, so their contents can be seen directly.

Top module: `uop_datapath`

## Requirements
- R1: While rst_n is low, the accumulator, data register, address register and program counter all clear to zero.
- R2: Field A codes: 0 no-op, 1 acc=acc+dat, 2 acc=0, 3 acc=acc+1, 4 acc=dat, 5 adr=dat[10:0], 6 adr=pc, 7 mem[adr]=dat.
- R3: Field B codes: 0 no-op, 1 acc=acc-dat, 2 acc=acc|dat, 3 acc=acc&dat, 4 dat=mem[adr], 5 dat=acc, 6 dat=dat+1, 7 dat[10:0]=pc. Code 7 leaves dat[15:11] unchanged.
- R4: Field C codes: 0 no-op, 1 acc=acc^dat, 2 acc=~acc, 3 acc shifted left with a zero entering bit 0, 4 acc shifted right with a zero entering bit 15, 5 pc=pc+1, 6 pc=adr, 7 no-op.
- R5: Every transfer uses register and memory values from before the clock edge. A read of mem[adr] in the same cycle as a write to mem[adr] returns the old word.
- R6: When several fields write the accumulator in one cycle, the field C result wins over field B, and field B wins over field A.
- R7: Accumulator and data-register arithmetic wraps modulo 2^16. The program counter and its increment wrap modulo 2^11.
- R8: A word written with field A code 7 is returned by a later field B code 4 at the same address.
- R9: sign_o equals acc[15]. zero_o is 1 exactly when all 16 accumulator bits are zero. indir_o equals dat[15]. map_o equals dat[14:11].
- R10: With all three fields at 0, every register and the memory keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the four registers |
| fld_a | input | 3 | First operation field |
| fld_b | input | 3 | Second operation field |
| fld_c | input | 3 | Third operation field |
| acc_q | output | 16 | Accumulator contents |
| dat_q | output | 16 | Data register contents |
| adr_q | output | 11 | Address register contents |
| pc_q | output | 11 | Program counter contents |
| sign_o | output | 1 | Accumulator bit 15 |
| zero_o | output | 1 | Accumulator is all zeros |
| indir_o | output | 1 | Data register bit 15 |
| map_o | output | 4 | Data register bits 14:11 |

## Verification
The four registers drive ports directly. A wrong decode or a wrong priority choice therefore shows up one edge after the offending field triple, as a wrong value on acc_q, dat_q, adr_q or pc_q. The status outputs depend on those registers alone, so they show the same error in the same cycle.

Memory faults are different, because memory can only be seen through the data register. A bad write or a bad address stays hidden until a later read at that address. It then appears on dat_q one edge after the read.

// File: rtl/uop_pkg.sv
package uop_pkg;

  typedef enum logic [2:0] {
    A_IDLE, A_ACC_ADD, A_ACC_ZERO, A_ACC_BUMP,
    A_ACC_GET, A_ADR_GET, A_ADR_PC, A_STORE
  } fld_a_e;

  typedef enum logic [2:0] {
    B_IDLE, B_ACC_SUB, B_ACC_IOR, B_ACC_MASK,
    B_DAT_LOAD, B_DAT_ACC, B_DAT_BUMP, B_DAT_PC
  } fld_b_e;

  typedef enum logic [2:0] {
    C_IDLE, C_ACC_XOR, C_ACC_INV, C_ACC_LSH,
    C_ACC_RSH, C_PC_BUMP, C_PC_ADR, C_SPARE
  } fld_c_e;

  typedef enum logic [3:0] {
    AC_KEEP, AC_ADD, AC_SUB, AC_IOR, AC_MASK, AC_XOR, AC_INV,
    AC_LSH, AC_RSH, AC_ZERO, AC_BUMP, AC_GET
  } ac_sel_e;

  typedef enum logic [2:0] {DT_KEEP, DT_MEM, DT_ACC, DT_BUMP, DT_PC} dt_sel_e;
  typedef enum logic [1:0] {AD_KEEP, AD_DAT, AD_PC} ad_sel_e;
  typedef enum logic [1:0] {PC_KEEP, PC_BUMP, PC_ADR} pc_sel_e;

  typedef struct packed {
    ac_sel_e ac;
    dt_sel_e dt;
    ad_sel_e ad;
    pc_sel_e pc;
    logic    we;
  } ctrl_t;

endpackage

// File: rtl/uop_decode.sv
module uop_decode
  import uop_pkg::*;
(
  input  logic [2:0] fld_a,
  input  logic [2:0] fld_b,
  input  logic [2:0] fld_c,
  output ctrl_t      ctrl
);
  fld_a_e op_a;
  fld_b_e op_b;
  fld_c_e op_c;

  assign op_a = fld_a_e'(fld_a);
  assign op_b = fld_b_e'(fld_b);
  assign op_c = fld_c_e'(fld_c);

  // Later fields overwrite the accumulator choice: C over B over A (R6)
  always_comb begin
    ctrl = '{ac: AC_KEEP, dt: DT_KEEP, ad: AD_KEEP, pc: PC_KEEP, we: 1'b0};
    case (op_a)
      A_ACC_ADD:  ctrl.ac = AC_ADD;
      A_ACC_ZERO: ctrl.ac = AC_ZERO;
      A_ACC_BUMP: ctrl.ac = AC_BUMP;
      A_ACC_GET:  ctrl.ac = AC_GET;
      A_ADR_GET:  ctrl.ad = AD_DAT;
      A_ADR_PC:   ctrl.ad = AD_PC;
      A_STORE:    ctrl.we = 1'b1;
      default:    ;
    endcase
    case (op_b)
      B_ACC_SUB:  ctrl.ac = AC_SUB;
      B_ACC_IOR:  ctrl.ac = AC_IOR;
      B_ACC_MASK: ctrl.ac = AC_MASK;
      B_DAT_LOAD: ctrl.dt = DT_MEM;
      B_DAT_ACC:  ctrl.dt = DT_ACC;
      B_DAT_BUMP: ctrl.dt = DT_BUMP;
      B_DAT_PC:   ctrl.dt = DT_PC;
      default:    ;
    endcase
    case (op_c)
      C_ACC_XOR:  ctrl.ac = AC_XOR;
      C_ACC_INV:  ctrl.ac = AC_INV;
      C_ACC_LSH:  ctrl.ac = AC_LSH;
      C_ACC_RSH:  ctrl.ac = AC_RSH;
      C_PC_BUMP:  ctrl.pc = PC_BUMP;
      C_PC_ADR:   ctrl.pc = PC_ADR;
      default:    ;  // C_IDLE and C_SPARE do nothing (R4)
    endcase
  end
endmodule

// File: rtl/uop_acc_unit.sv
module uop_acc_unit
  import uop_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ac_sel_e       sel,
  input  logic [DW-1:0] dat,
  output logic [DW-1:0] acc
);
  function automatic logic [DW-1:0] acc_calc(ac_sel_e s, logic [DW-1:0] a, logic [DW-1:0] d);
    case (s)
      AC_ADD:  return a + d;
      AC_SUB:  return a - d;
      AC_IOR:  return a | d;
      AC_MASK: return a & d;
      AC_XOR:  return a ^ d;
      AC_INV:  return ~a;
      AC_LSH:  return {a[DW-2:0], 1'b0};
      AC_RSH:  return {1'b0, a[DW-1:1]};
      AC_ZERO: return '0;
      AC_BUMP: return a + 1'b1;
      AC_GET:  return d;
      default: return a;
    endcase
  endfunction

  logic acc_clear_evt, acc_hold_evt;
  assign acc_clear_evt = (sel == AC_ZERO);
  assign acc_hold_evt  = (sel == AC_KEEP);

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_calc(sel, acc, dat);
  end

  assert_acc_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clear_evt |=> (acc == '0));
  assert_acc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hold_evt |=> $stable(acc));
endmodule

// File: rtl/uop_dat_unit.sv
module uop_dat_unit
  import uop_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dt_sel_e       sel,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] mem_rd,
  input  logic [AW-1:0] pc,
  output logic [DW-1:0] dat
);
  logic dat_pc_evt, dat_hold_evt;
  assign dat_pc_evt   = (sel == DT_PC);
  assign dat_hold_evt = (sel == DT_KEEP);

  always_ff @(posedge clk) begin
    if (!rst_n) dat <= '0;
    else begin
      case (sel)
        DT_MEM:  dat <= mem_rd;
        DT_ACC:  dat <= acc;
        DT_BUMP: dat <= dat + 1'b1;
        DT_PC:   dat[AW-1:0] <= pc;
        default: ;
      endcase
    end
  end

  assert_dat_top_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dat_pc_evt |=> (dat[DW-1:AW] == $past(dat[DW-1:AW])));
  assert_dat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dat_hold_evt |=> $stable(dat));
endmodule

// File: rtl/uop_addr_unit.sv
module uop_addr_unit
  import uop_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ad_sel_e       ad_sel,
  input  pc_sel_e       pc_sel,
  input  logic [AW-1:0] dat_lo,
  output logic [AW-1:0] adr,
  output logic [AW-1:0] pc
);
  logic pc_step_evt, adr_hold_evt;
  assign pc_step_evt  = (pc_sel == PC_BUMP);
  assign adr_hold_evt = (ad_sel == AD_KEEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adr <= '0;
      pc  <= '0;
    end else begin
      case (ad_sel)
        AD_DAT:  adr <= dat_lo;
        AD_PC:   adr <= pc;
        default: ;
      endcase
      case (pc_sel)
        PC_BUMP: pc <= pc + 1'b1;
        PC_ADR:  pc <= adr;
        default: ;
      endcase
    end
  end

  assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_step_evt |=> (pc == AW'($past(pc) + 1'b1)));
  assert_adr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    adr_hold_evt |=> $stable(adr));
endmodule

// File: rtl/uop_mem.sv
module uop_mem #(
  parameter int DW = 16,
  parameter int AW = 11,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  // Read is combinational, so a same-edge write is not seen (R5)
  assign rdata = store[addr];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end
endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
  import uop_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 11,
  localparam int MW = DW - 1 - AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    fld_a,
  input  logic [2:0]    fld_b,
  input  logic [2:0]    fld_c,
  output logic [DW-1:0] acc_q,
  output logic [DW-1:0] dat_q,
  output logic [AW-1:0] adr_q,
  output logic [AW-1:0] pc_q,
  output logic          sign_o,
  output logic          zero_o,
  output logic          indir_o,
  output logic [MW-1:0] map_o
);
  ctrl_t         ctrl;
  logic [DW-1:0] mem_rd;

  uop_decode u_dec (.fld_a(fld_a), .fld_b(fld_b), .fld_c(fld_c), .ctrl(ctrl));

  uop_acc_unit #(.DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .sel(ctrl.ac), .dat(dat_q), .acc(acc_q));

  uop_dat_unit #(.DW(DW), .AW(AW)) u_dat (
    .clk(clk), .rst_n(rst_n), .sel(ctrl.dt), .acc(acc_q),
    .mem_rd(mem_rd), .pc(pc_q), .dat(dat_q));

  uop_addr_unit #(.AW(AW)) u_adr (
    .clk(clk), .rst_n(rst_n), .ad_sel(ctrl.ad), .pc_sel(ctrl.pc),
    .dat_lo(dat_q[AW-1:0]), .adr(adr_q), .pc(pc_q));

  uop_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .we(ctrl.we), .addr(adr_q), .wdata(dat_q), .rdata(mem_rd));

  assign sign_o  = acc_q[DW-1];
  assign zero_o  = (acc_q == '0);
  assign indir_o = dat_q[DW-1];
  assign map_o   = dat_q[DW-2:AW];

  // Sign and zero can never be raised together (R9)
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sign_o && zero_o));
endmodule

// File: tb/uop_datapath_bench.sv
module uop_datapath_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fa = 3'd0, fb = 3'd0, fc = 3'd0;
  logic [15:0] acc_q, dat_q;
  logic [10:0] adr_q, pc_q;
  logic        sign_o, zero_o, indir_o;
  logic [3:0]  map_o;

  int checks = 0;
  int fails  = 0;

  logic [15:0] m_acc, m_dat;
  logic [10:0] m_adr, m_pc;
  logic [15:0] m_mem [2048];

  always #5 clk = ~clk;

  uop_datapath u_uop_datapath (
    .clk(clk), .rst_n(rst_n), .fld_a(fa), .fld_b(fb), .fld_c(fc),
    .acc_q(acc_q), .dat_q(dat_q), .adr_q(adr_q), .pc_q(pc_q),
    .sign_o(sign_o), .zero_o(zero_o), .indir_o(indir_o), .map_o(map_o));

  task automatic compare(input string tag);
    bit bad = 0;
    checks++;
    if (acc_q !== m_acc) begin bad = 1; $display("FAIL %s acc actual %h expected %h", tag, acc_q, m_acc); end
    if (dat_q !== m_dat) begin bad = 1; $display("FAIL %s dat actual %h expected %h", tag, dat_q, m_dat); end
    if (adr_q !== m_adr) begin bad = 1; $display("FAIL %s adr actual %h expected %h", tag, adr_q, m_adr); end
    if (pc_q  !== m_pc)  begin bad = 1; $display("FAIL %s pc actual %h expected %h", tag, pc_q, m_pc); end
    if ({sign_o, zero_o, indir_o, map_o} !== {m_acc[15], m_acc == 16'd0, m_dat[15], m_dat[14:11]}) begin
      bad = 1;
      $display("FAIL %s R9 flags actual %b expected %b", tag, {sign_o, zero_o, indir_o, map_o},
               {m_acc[15], m_acc == 16'd0, m_dat[15], m_dat[14:11]});
    end
    if (bad) fails++;
  endtask

  // Model: apply fields in order A, B, C, each reading pre-edge state
  task automatic step(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c, input string tag);
    logic [15:0] n_acc = m_acc, n_dat = m_dat;
    logic [10:0] n_adr = m_adr, n_pc = m_pc;
    @(negedge clk);
    fa = a; fb = b; fc = c;
    case (a)
      3'd1: n_acc = m_acc + m_dat;
      3'd2: n_acc = 16'd0;
      3'd3: n_acc = m_acc + 16'd1;
      3'd4: n_acc = m_dat;
      3'd5: n_adr = m_dat[10:0];
      3'd6: n_adr = m_pc;
      default: ;
    endcase
    case (b)
      3'd1: n_acc = m_acc - m_dat;
      3'd2: n_acc = m_acc | m_dat;
      3'd3: n_acc = m_acc & m_dat;
      3'd4: n_dat = m_mem[m_adr];
      3'd5: n_dat = m_acc;
      3'd6: n_dat = m_dat + 16'd1;
      3'd7: n_dat = {m_dat[15:11], m_pc};
      default: ;
    endcase
    case (c)
      3'd1: n_acc = m_acc ^ m_dat;
      3'd2: n_acc = ~m_acc;
      3'd3: n_acc = m_acc << 1;
      3'd4: n_acc = m_acc >> 1;
      3'd5: n_pc = m_pc + 11'd1;
      3'd6: n_pc = m_adr;
      default: ;
    endcase
    if (a == 3'd7) m_mem[m_adr] = m_dat;
    m_acc = n_acc; m_dat = n_dat; m_adr = n_adr; m_pc = n_pc;
    @(negedge clk);
    fa = 3'd0; fb = 3'd0; fc = 3'd0;
    compare(tag);
  endtask

  task automatic load_acc(input logic [15:0] v);
    step(3'd2, 3'd0, 3'd0, "R2 clear setup");
    for (int i = 15; i >= 0; i--) begin
      step(3'd0, 3'd0, 3'd3, "R4 shift setup");
      if (v[i]) step(3'd3, 3'd0, 3'd0, "R2 bump setup");
    end
  endtask

  task automatic load_dat(input logic [15:0] v);
    load_acc(v);
    step(3'd0, 3'd5, 3'd0, "R3 dat from acc");
  endtask

  task automatic t_reset;
    m_acc = 0; m_dat = 0; m_adr = 0; m_pc = 0;
    fa = 3'd5; fb = 3'd6; fc = 3'd5;  // fields ignored during reset (R1)
    repeat (3) @(negedge clk);
    fa = 0; fb = 0; fc = 0;
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 reset state");
  endtask

  task automatic t_field_a;
    load_dat(16'h0123);
    load_acc(16'h1000);
    step(3'd1, 3'd0, 3'd0, "R2 acc add");
    step(3'd4, 3'd0, 3'd0, "R2 acc from dat");
    step(3'd3, 3'd0, 3'd0, "R2 acc bump");
    step(3'd5, 3'd0, 3'd0, "R2 adr from dat");
    step(3'd6, 3'd0, 3'd0, "R2 adr from pc");
    step(3'd2, 3'd0, 3'd0, "R2 acc zero");
  endtask

  task automatic t_field_b;
    load_dat(16'h0F0F);
    load_acc(16'h3C3C);
    step(3'd0, 3'd1, 3'd0, "R3 acc sub");
    step(3'd0, 3'd2, 3'd0, "R3 acc or");
    step(3'd0, 3'd3, 3'd0, "R3 acc and");
    step(3'd0, 3'd6, 3'd0, "R3 dat bump");
    load_dat(16'hA800);
    repeat (5) step(3'd0, 3'd0, 3'd5, "R4 pc bump");
    step(3'd0, 3'd7, 3'd0, "R3 dat low from pc keeps top");
  endtask

  task automatic t_field_c;
    load_dat(16'h5AA5);
    load_acc(16'h8421);
    step(3'd0, 3'd0, 3'd1, "R4 acc xor");
    step(3'd0, 3'd0, 3'd2, "R4 acc invert");
    step(3'd0, 3'd0, 3'd3, "R4 acc shift left zero fill");
    step(3'd0, 3'd0, 3'd4, "R4 acc shift right zero fill");
    step(3'd0, 3'd0, 3'd7, "R4 spare code no-op");
    step(3'd5, 3'd0, 3'd0, "R4 adr setup");
    step(3'd0, 3'd0, 3'd6, "R4 pc from adr");
  endtask

  task automatic t_parallel;
    load_dat(16'h0155);
    step(3'd5, 3'd6, 3'd6, "R5 adr/dat/pc swap");
    step(3'd6, 3'd0, 3'd5, "R5 adr from old pc with pc bump");
    step(3'd1, 3'd5, 3'd0, "R5 add with dat from acc");
  endtask

  task automatic t_priority;
    load_dat(16'h00F0);
    load_acc(16'h1234);
    step(3'd3, 3'd1, 3'd2, "R6 C over B over A");
    step(3'd1, 3'd2, 3'd0, "R6 B over A");
    step(3'd4, 3'd0, 3'd3, "R6 C over A");
    step(3'd2, 3'd3, 3'd4, "R6 C over B and A");
  endtask

  task automatic t_wrap;
    load_acc(16'hFFFF);
    step(3'd3, 3'd0, 3'd0, "R7 acc bump wraps");
    load_dat(16'h0001);
    step(3'd2, 3'd0, 3'd0, "R7 clear");
    step(3'd0, 3'd1, 3'd0, "R7 sub borrows to all ones");
    load_dat(16'hFFFF);
    step(3'd0, 3'd6, 3'd0, "R7 dat bump wraps");
    load_dat(16'h07FF);
    step(3'd5, 3'd0, 3'd0, "R7 adr max");
    step(3'd0, 3'd0, 3'd6, "R7 pc max");
    step(3'd0, 3'd0, 3'd5, "R7 pc wraps");
  endtask

  task automatic t_memory;
    load_dat(16'h0005);
    step(3'd5, 3'd0, 3'd0, "R8 adr 5");
    load_dat(16'hBEEF);
    step(3'd7, 3'd0, 3'd0, "R8 store");
    step(3'd0, 3'd6, 3'd0, "R8 dat bump");
    step(3'd7, 3'd4, 3'd0, "R5 read old word during store");
    step(3'd0, 3'd4, 3'd0, "R8 read back newer word");
    load_dat(16'h0006);
    step(3'd5, 3'd0, 3'd0, "R8 adr 6");
    load_dat(16'h1357);
    step(3'd7, 3'd0, 3'd0, "R8 store at 6");
    load_dat(16'h0005);
    step(3'd5, 3'd0, 3'd0, "R8 back to 5");
    step(3'd0, 3'd4, 3'd0, "R8 word at 5 untouched by 6");
  endtask

  task automatic t_status;
    load_acc(16'h8000);
    load_dat(16'hF800);
    step(3'd0, 3'd0, 3'd0, "R9 sign and map");
    load_dat(16'h4800);
    step(3'd2, 3'd0, 3'd0, "R9 zero flag");
  endtask

  task automatic t_idle;
    load_dat(16'h2468);
    repeat (3) step(3'd0, 3'd0, 3'd0, "R10 all idle holds");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_field_a();
    t_field_b();
    t_field_c();
    t_parallel();
    t_priority();
    t_wrap();
    t_memory();
    t_status();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule